// File: doc/BRIEF.md
# Signed Timebase Rate Trim with Frequency-Test Tone

This block sits between a 32,768 Hz oscillator enable and the seconds counter of a real-time clock. It runs its own prescaler that turns oscillator ticks into a one-cycle pulse per second. That prescaler can be made to run faster or slower by a signed trim code. A positive trim removes oscillator cycles from the prescaler by letting it advance two counts on chosen ticks. A negative trim inserts cycles by holding the prescaler still on chosen ticks. The chosen ticks are spread evenly across a fixed correction period, which is 64 minutes by default. The speed-up step is twice the slow-down step. The default is 512 cycles removed or 256 cycles inserted per unit of magnitude in each period.

The block also takes part in seconds-register readback. While the frequency-test enable is set, the seconds register is being read, and the read-freeze bit is clear, the least significant bit returned is a test tone instead of the stored seconds bit. The tone is one bit of a free-running raw tick counter that calibration never touches, so it toggles at 512 Hz when the oscillator is at nominal rate. All pins are plain control and status levels. There is no streaming data path, so no valid/ready handshake is used.

Top module: `rtc_rate_trim`

## Requirements
- R1: With trim magnitude `cal_code[4:0]` equal to zero, `pps` fires exactly once every DIV oscillator ticks, whatever the value of the sign bit `cal_code[5]`.
- R2: With sign `cal_code[5]=1` and magnitude m, the prescaler advances DIV*PERIOD_SEC + m*POS_UNIT counts per correction period, so the clock runs fast.
- R3: With sign `cal_code[5]=0` and magnitude m, the prescaler advances DIV*PERIOD_SEC - m*NEG_UNIT counts per correction period, so the clock runs slow.
- R4: Each correction period contains exactly m*unit correction events. They fall on evenly spaced ticks chosen by a running accumulator, and at most one event occurs per tick.
- R5: The trim code is sampled only on the last tick of a correction period. A change made part way through a period first takes effect in the next period. After reset the active trim is zero until the first period ends.
- R6: Reset clears the prescaler, period counter, accumulator, active trim and raw tone counter, and holds `pps` low. `pps` is a single-cycle pulse that follows a cycle in which `osc_tick` was high.
- R7: While `test_en=1`, `sec_read=1` and `freeze_rd=0`, `lsb_out` equals bit TONE_TAP of the raw tick counter. With the default TONE_TAP of 5 this is a 512 Hz square wave.
- R8: Outside the condition of R7, `lsb_out` equals `sec_lsb`. This applies when the freeze bit is set, when the register is not being read, and after the test enable is cleared.
- R9: The test tone counts raw oscillator ticks. Its phase after k ticks from reset is bit TONE_TAP of k, independent of the trim code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cal_code | input | 6 | Trim code: bit 5 sign (1 = faster), bits 4:0 magnitude |
| test_en | input | 1 | Frequency-test enable bit |
| sec_read | input | 1 | High while the seconds register is being read |
| freeze_rd | input | 1 | Read-freeze bit of the control register |
| sec_lsb | input | 1 | Stored least significant bit of the seconds register |
| pps | output | 1 | Corrected one-pulse-per-second tick |
| lsb_out | output | 1 | Seconds LSB as returned on readback |

## Verification
Several rules are checked on every cycle. `pps` may only follow an oscillator tick and never lasts two cycles. The active trim changes only right after a period boundary. Each finished period must have seen exactly magnitude times unit events. The readback bit must follow either the tone or `sec_lsb` as the test, read and freeze inputs dictate. The bench scenarios cover what needs counting over many ticks: pulse totals across several periods for zero, small, mid and full-scale trims in both directions, the delayed effect of a trim changed mid-period, and the tone phase after known tick counts.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef struct packed {
    logic       fast;
    logic [4:0] mag;
  } trim_code_t;

  localparam int MAG_MAX = 31;
endpackage

// File: rtl/trim_spreader.sv
module trim_spreader
  import rtc_trim_pkg::*;
#(
  parameter int DIV        = 32768,
  parameter int PERIOD_SEC = 3840,
  parameter int POS_UNIT   = 512,
  parameter int NEG_UNIT   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [5:0] cal_code,
  output logic [5:0] act_code,
  output logic       period_wrap,
  output logic       ev_fast,
  output logic       ev_slow
);
  localparam int N  = DIV * PERIOD_SEC;
  localparam int PW = $clog2(N);
  localparam int AW = PW + 2;

  trim_code_t       act;
  logic [PW-1:0]    pcnt;
  logic [AW-1:0]    acc;
  logic [AW-1:0]    e_amt;
  logic [AW-1:0]    sum;
  logic             hit;

  always_comb begin
    e_amt = AW'(act.mag) * (act.fast ? AW'(POS_UNIT) : AW'(NEG_UNIT));
    sum   = acc + e_amt;
    hit   = (sum >= AW'(N));
  end

  assign period_wrap = osc_tick && (pcnt == PW'(N - 1));
  assign ev_fast     = osc_tick && hit && act.fast;
  assign ev_slow     = osc_tick && hit && !act.fast;
  assign act_code    = act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      acc  <= '0;
      act  <= '0;
    end else if (osc_tick) begin
      if (period_wrap) begin
        pcnt <= '0;
        acc  <= '0;
        act  <= trim_code_t'(cal_code);
      end else begin
        pcnt <= pcnt + 1'b1;
        acc  <= hit ? (sum - AW'(N)) : sum;
      end
    end
  end
endmodule

// File: rtl/trim_divider.sv
module trim_divider #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic ev_fast,
  input  logic ev_slow,
  output logic pps
);
  localparam int CW = $clog2(DIV) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] step;
  logic [CW-1:0] nxt;
  logic          roll;

  always_comb begin
    if (ev_fast)      step = CW'(2);
    else if (ev_slow) step = '0;
    else              step = CW'(1);
    nxt  = cnt + step;
    roll = (nxt >= CW'(DIV));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      pps <= 1'b0;
    end else begin
      pps <= osc_tick && roll;
      if (osc_tick) cnt <= roll ? (nxt - CW'(DIV)) : nxt;
    end
  end
endmodule

// File: rtl/trim_tone.sv
module trim_tone #(
  parameter int TONE_TAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic test_en,
  input  logic sec_read,
  input  logic freeze_rd,
  input  logic sec_lsb,
  output logic tone,
  output logic lsb_out
);
  logic [TONE_TAP:0] raw;

  always_ff @(posedge clk) begin
    if (!rst_n)        raw <= '0;
    else if (osc_tick) raw <= raw + 1'b1;
  end

  assign tone    = raw[TONE_TAP];
  assign lsb_out = (test_en && sec_read && !freeze_rd) ? tone : sec_lsb;
endmodule

// File: rtl/rtc_rate_trim.sv
module rtc_rate_trim #(
  parameter int DIV        = 32768,
  parameter int PERIOD_SEC = 3840,
  parameter int POS_UNIT   = 512,
  parameter int NEG_UNIT   = 256,
  parameter int TONE_TAP   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [5:0] cal_code,
  input  logic       test_en,
  input  logic       sec_read,
  input  logic       freeze_rd,
  input  logic       sec_lsb,
  output logic       pps,
  output logic       lsb_out
);
  logic [5:0] act_code;
  logic       period_wrap;
  logic       ev_fast;
  logic       ev_slow;
  logic       tone;

  trim_spreader #(
    .DIV(DIV), .PERIOD_SEC(PERIOD_SEC), .POS_UNIT(POS_UNIT), .NEG_UNIT(NEG_UNIT)
  ) u_spread (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_code(cal_code),
    .act_code(act_code), .period_wrap(period_wrap),
    .ev_fast(ev_fast), .ev_slow(ev_slow)
  );

  trim_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .ev_fast(ev_fast), .ev_slow(ev_slow), .pps(pps)
  );

  trim_tone #(.TONE_TAP(TONE_TAP)) u_tone (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .test_en(test_en),
    .sec_read(sec_read), .freeze_rd(freeze_rd), .sec_lsb(sec_lsb),
    .tone(tone), .lsb_out(lsb_out)
  );
endmodule

// File: rtl/rtc_rate_trim_chk.sv
module rtc_rate_trim_chk #(
  parameter int POS_UNIT = 512,
  parameter int NEG_UNIT = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic       pps,
  input logic       lsb_out,
  input logic       sec_lsb,
  input logic       test_en,
  input logic       sec_read,
  input logic       freeze_rd,
  input logic       tone,
  input logic       period_wrap,
  input logic       ev_fast,
  input logic       ev_slow,
  input logic [5:0] act_code
);
  logic [31:0] ev_cnt;
  logic [31:0] ev_due;
  logic        ev_now;
  logic        show_tone;

  assign ev_now    = ev_fast || ev_slow;
  assign ev_due    = 32'(act_code[4:0]) * (act_code[5] ? 32'(POS_UNIT) : 32'(NEG_UNIT));
  assign show_tone = test_en && sec_read && !freeze_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)                        ev_cnt <= '0;
    else if (osc_tick && period_wrap)  ev_cnt <= '0;
    else if (ev_now)                   ev_cnt <= ev_cnt + 1'b1;
  end

  AST_PPS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pps |-> $past(osc_tick)); // R6
  AST_PPS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pps |=> !pps); // R6
  AST_TRIM_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> $past(period_wrap)); // R5
  AST_EVENTS_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && period_wrap) |-> (ev_cnt + 32'(ev_now)) == ev_due); // R4
  AST_TONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tone) |-> $past(osc_tick)); // R9
  AST_READ_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    show_tone |-> lsb_out == tone); // R7
  AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !show_tone |-> lsb_out == sec_lsb); // R8
endmodule

bind rtc_rate_trim rtc_rate_trim_chk #(.POS_UNIT(POS_UNIT), .NEG_UNIT(NEG_UNIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pps(pps), .lsb_out(lsb_out),
  .sec_lsb(sec_lsb), .test_en(test_en), .sec_read(sec_read), .freeze_rd(freeze_rd),
  .tone(tone), .period_wrap(period_wrap), .ev_fast(ev_fast), .ev_slow(ev_slow),
  .act_code(act_code)
);

// File: tb/rtc_rate_trim_bench.sv
module rtc_rate_trim_bench;
  localparam int DIV = 16, PSEC = 4, PU = 2, NU = 1, TAP = 2;
  localparam int N = DIV * PSEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic [5:0] cal_code = '0;
  logic test_en = 1'b0, sec_read = 1'b0, freeze_rd = 1'b0, sec_lsb = 1'b0;
  logic pps, lsb_out;

  int n_chk = 0, n_bad = 0, pps_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_rate_trim #(.DIV(DIV), .PERIOD_SEC(PSEC), .POS_UNIT(PU), .NEG_UNIT(NU),
                  .TONE_TAP(TAP)) u_rtc_rate_trim (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_code(cal_code),
    .test_en(test_en), .sec_read(sec_read), .freeze_rd(freeze_rd),
    .sec_lsb(sec_lsb), .pps(pps), .lsb_out(lsb_out)
  );

  always @(negedge clk) if (rst_n && pps) pps_seen++;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [5:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    cal_code = code;
    repeat (3) @(negedge clk);
    pps_seen = 0;
    rst_n = 1'b1;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // pulses after one zero-trim period plus p periods advancing adv counts each
  function automatic int expect_pps(int adv, int p);
    return (N + adv * p) / DIV;
  endfunction

  task automatic t_reset();
    do_reset(6'h3F);
    sec_lsb = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 pps low after reset", int'(pps), 0);
    check("R8 readback passes sec_lsb", int'(lsb_out), 1);
    sec_lsb = 1'b0;
  endtask

  task automatic t_zero();
    do_reset(6'h00);
    ticks(3 * N);
    check("R1 zero trim, sign 0", pps_seen, 3 * N / DIV);
    do_reset(6'h20);
    ticks(3 * N);
    check("R1 zero trim, sign 1", pps_seen, 3 * N / DIV);
  endtask

  task automatic t_fast();
    do_reset(6'h25);
    ticks(9 * N);
    check("R2 fast trim 5", pps_seen, expect_pps(N + 5 * PU, 8));
    do_reset(6'h3F);
    ticks(2 * N);
    check("R2 fast trim full scale", pps_seen, expect_pps(N + 31 * PU, 1));
  endtask

  task automatic t_slow();
    do_reset(6'h0A);
    ticks(9 * N);
    check("R3 slow trim 10", pps_seen, expect_pps(N - 10 * NU, 8));
    do_reset(6'h1F);
    ticks(2 * N);
    check("R3 slow trim full scale", pps_seen, expect_pps(N - 31 * NU, 1));
    do_reset(6'h10);
    ticks(2 * N);
    check("R4 exact inserted count, trim 16", pps_seen, expect_pps(N - 16 * NU, 1));
  endtask

  task automatic t_next_period();
    do_reset(6'h00);
    ticks(N / 2);
    cal_code = 6'h3F;
    ticks(N / 2);
    check("R5 mid-period change not applied", pps_seen, N / DIV);
    ticks(N);
    check("R5 change applied next period", pps_seen, expect_pps(N + 31 * PU, 1));
  endtask

  task automatic t_tone();
    do_reset(6'h3F);
    test_en = 1'b1; sec_read = 1'b1; freeze_rd = 1'b0; sec_lsb = 1'b0;
    ticks(4);
    check("R7 tone high after 4 ticks", int'(lsb_out), 1);
    ticks(4);
    check("R7 tone low after 8 ticks", int'(lsb_out), 0);
    ticks(4);
    check("R9 tone after 12 ticks ignores trim", int'(lsb_out), 1);
    freeze_rd = 1'b1;
    @(negedge clk);
    check("R8 freeze returns sec_lsb", int'(lsb_out), 0);
    freeze_rd = 1'b0; sec_read = 1'b0;
    @(negedge clk);
    check("R8 no read returns sec_lsb", int'(lsb_out), 0);
    sec_read = 1'b1; test_en = 1'b0;
    @(negedge clk);
    check("R8 test cleared returns sec_lsb", int'(lsb_out), 0);
    test_en = 1'b1;
    ticks(N + 4);
    check("R9 tone after 80 ticks", int'(lsb_out), ((N + 16) >> TAP) & 1);
    test_en = 1'b0; sec_read = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_zero();
    t_fast();
    t_slow();
    t_next_period();
    t_tone();
    finish_run();
  end
endmodule